// File: doc/BRIEF.md
# Fractional SIMD Multiply-Accumulate Unit

This block multiplies packed signed fractional data and accumulates the results in a bank of wide accumulators. Each 32-bit source word holds two signed Q15 halves. Both lane products are formed in parallel, converted to Q31 with saturation, and combined as a sum or a difference. The combined value is then added to, or subtracted from, one of four 64-bit Q32.31 accumulators.

The block also has two 32-bit add operations. One of them produces a carry flag and the other consumes it, so a pair of them makes a 64-bit add. An extraction operation reads a 32-bit window out of an accumulator at a chosen bit offset. It comes in a plain form, a rounding form and a rounding-plus-saturating form. Sticky flags record product saturation for each accumulator and clamping during extraction. A single control write replaces all the flags at once.

Operations are issued one per clock, with no stall, including back-to-back operations on the same accumulator. Each operation completes on the second rising edge after issue.

Top module: `simd_mac_unit`

## Requirements
- R1: A lane product is the Q15 product doubled into Q31, except that 0x8000 times 0x8000 gives 0x7FFF_FFFF. Such a saturation sets the sticky overflow flag `ovf_o[acc_sel]` of the target accumulator.
- R2: Op code 0 (dot add) adds the sign-extended sum of the left-lane product (bits 31:16) and the right-lane product (bits 15:0) to the selected accumulator. The addition wraps modulo 2^64.
- R3: Op code 1 (dot subtract) subtracts the same sign-extended sum of the two lane products from the selected accumulator.
- R4: Op code 2 (cross) adds the left-lane product minus the right-lane product to the selected accumulator.
- R5: Op code 3 returns `src_a_i + src_b_i` on `result_o` and loads the carry out into `carry_o`.
- R6: Op code 4 returns `src_a_i + src_b_i + carry_o` and leaves the carry flag unchanged.
- R7: Op code 5 returns bits [shift+31:shift] of the accumulator, shifted arithmetically.
- R8: Op code 6 is op code 5 with one added at bit shift-1 before the shift when shift is above 0. The addition uses 65-bit arithmetic.
- R9: Op code 7 rounds as op code 6 does, then clamps the result to the range 0x8000_0000 to 0x7FFF_FFFF. A clamp sets the sticky flag `ext_sat_o`.
- R10: One operation is accepted every clock, and back-to-back operations on the same accumulator see each other's results. Results, accumulators and flags update on the second rising edge after issue.
- R11: Flags are sticky until `ctl_wr_i`, which writes `ctl_wdata_i` on the next edge: bits [3:0] go to the overflow flags, bit 4 to the extraction saturation flag and bit 5 to the carry. A flag raised by an operation completing on that same edge is kept.
- R12: After reset, all accumulators, flags, `result_o` and `result_valid_o` are zero.
- R13: Multiply-accumulate operations and idle cycles leave `result_o` unchanged and `result_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Issue an operation this cycle |
| op_code_i | input | 3 | Operation code, 0 to 7 |
| acc_sel_i | input | 2 | Accumulator index |
| src_a_i | input | 32 | First packed operand |
| src_b_i | input | 32 | Second packed operand |
| shift_i | input | 5 | Extraction bit offset |
| ctl_wr_i | input | 1 | Replace the flags |
| ctl_wdata_i | input | 6 | New flag values |
| result_o | output | 32 | Add or extraction result |
| result_valid_o | output | 1 | `result_o` updated on the last edge |
| ovf_o | output | 4 | Sticky product overflow, one bit per accumulator |
| ext_sat_o | output | 1 | Sticky extraction clamp flag |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions assume that `op_valid_i`, `op_code_i` and `ctl_wr_i` are never unknown. Every op code is legal, so no further constraint is placed on the inputs. The stimulus keeps to this by driving every control input to a known value on every cycle, including during reset.

Operand halves are biased toward 0x8000, 0x7FFF and 0xFFFF. Dense streams hit the same accumulator back to back, and flag writes occur at random, some of them on the same edge as a flag-raising operation.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  typedef enum logic [2:0] {
    OP_DOT_ADD = 3'd0,
    OP_DOT_SUB = 3'd1,
    OP_CROSS   = 3'd2,
    OP_ADD_CO  = 3'd3,
    OP_ADD_CI  = 3'd4,
    OP_EXT     = 3'd5,
    OP_EXT_R   = 3'd6,
    OP_EXT_RS  = 3'd7
  } mac_op_e;
endpackage

// File: rtl/q15_mul.sv
module q15_mul #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o,
  output logic              sat_o
);
  localparam logic [HALF_W-1:0] MIN_V = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] MAX_P = {1'b0, {(PROD_W-1){1'b1}}};

  logic signed [PROD_W-1:0] full;

  assign full   = $signed(a_i) * $signed(b_i);
  assign sat_o  = (a_i == MIN_V) && (b_i == MIN_V);
  assign prod_o = sat_o ? MAX_P : {full[PROD_W-2:0], 1'b0};
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned N_ACC = 4,
  localparam int unsigned SEL_W = $clog2(N_ACC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [ACC_W-1:0]            wdata_i,
  output logic [N_ACC-1:0][ACC_W-1:0] acc_o
);
  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            acc_o[i] <= '0;
      else if (we_i && sel_i == SEL_W'(i))    acc_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/extract_unit.sv
module extract_unit #(
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic              rnd_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] res_o,
  output logic              clamp_o
);
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W:0] ext, bias, sum, shv;
  logic fits, over, under;

  always_comb begin
    ext  = {acc_i[ACC_W-1], acc_i};
    bias = '0;
    if (rnd_i && shift_i != '0) bias = (ACC_W+1)'(1) << (shift_i - 1'b1);
    sum  = ext + bias;
    shv  = sum >>> shift_i;
    // result fits when all bits above the sign position agree
    fits  = (&shv[ACC_W:DATA_W-1]) || !(|shv[ACC_W:DATA_W-1]);
    over  = sat_i && !fits && !shv[ACC_W];
    under = sat_i && !fits &&  shv[ACC_W];
    clamp_o = over || under;
    res_o = over ? MAX_V : under ? MIN_V : shv[DATA_W-1:0];
  end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit import simd_mac_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned N_ACC  = 4,
  localparam int unsigned SEL_W = $clog2(N_ACC),
  localparam int unsigned SH_W  = $clog2(DATA_W),
  localparam int unsigned FLAG_W = N_ACC + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_code_i,
  input  logic [SEL_W-1:0]  acc_sel_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic              ctl_wr_i,
  input  logic [FLAG_W-1:0] ctl_wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic [N_ACC-1:0]  ovf_o,
  output logic              ext_sat_o,
  output logic              carry_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned EXT_W  = ACC_W - DATA_W;

  // lane 1 = left half, lane 0 = right half
  logic [1:0][DATA_W-1:0] prod;
  logic [1:0]             prod_sat;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    q15_mul #(.HALF_W(HALF_W)) u_mul (
      .a_i   (src_a_i[l*HALF_W +: HALF_W]),
      .b_i   (src_b_i[l*HALF_W +: HALF_W]),
      .prod_o(prod[l]),
      .sat_o (prod_sat[l])
    );
  end

  // stage 1
  logic                   s1_valid;
  mac_op_e                s1_op;
  logic [SEL_W-1:0]       s1_sel;
  logic [1:0][DATA_W-1:0] s1_prod;
  logic [1:0]             s1_sat;
  logic [DATA_W-1:0]      s1_a, s1_b;
  logic [SH_W-1:0]        s1_shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_DOT_ADD;
      s1_sel   <= '0;
      s1_prod  <= '0;
      s1_sat   <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_shift <= '0;
    end else begin
      s1_valid <= op_valid_i;
      s1_op    <= mac_op_e'(op_code_i);
      s1_sel   <= acc_sel_i;
      s1_prod  <= prod;
      s1_sat   <= prod_sat;
      s1_a     <= src_a_i;
      s1_b     <= src_b_i;
      s1_shift <= shift_i;
    end
  end

  // stage 2: read-modify-write in one cycle, so no forwarding path is needed
  logic [N_ACC-1:0][ACC_W-1:0] acc_all;
  logic [ACC_W-1:0]  acc_rd, p_hi, p_lo, combo, acc_nx;
  logic              is_mac, is_add, is_ext;
  logic [DATA_W:0]   add_wide;
  logic [DATA_W-1:0] ext_res;
  logic              ext_clamp;

  assign acc_rd = acc_all[s1_sel];
  assign is_mac = s1_valid && (s1_op == OP_DOT_ADD || s1_op == OP_DOT_SUB || s1_op == OP_CROSS);
  assign is_add = s1_valid && (s1_op == OP_ADD_CO || s1_op == OP_ADD_CI);
  assign is_ext = s1_valid && (s1_op == OP_EXT || s1_op == OP_EXT_R || s1_op == OP_EXT_RS);

  always_comb begin
    p_hi   = {{EXT_W{s1_prod[1][DATA_W-1]}}, s1_prod[1]};
    p_lo   = {{EXT_W{s1_prod[0][DATA_W-1]}}, s1_prod[0]};
    combo  = (s1_op == OP_CROSS) ? p_hi - p_lo : p_hi + p_lo;
    acc_nx = (s1_op == OP_DOT_SUB) ? acc_rd - combo : acc_rd + combo;
  end

  assign add_wide = {1'b0, s1_a} + {1'b0, s1_b}
                  + (DATA_W+1)'(s1_op == OP_ADD_CI && carry_o);

  acc_bank #(.ACC_W(ACC_W), .N_ACC(N_ACC)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (is_mac),
    .sel_i  (s1_sel),
    .wdata_i(acc_nx),
    .acc_o  (acc_all)
  );

  extract_unit #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_ext (
    .acc_i  (acc_rd),
    .shift_i(s1_shift),
    .rnd_i  (s1_op == OP_EXT_R || s1_op == OP_EXT_RS),
    .sat_i  (s1_op == OP_EXT_RS),
    .res_o  (ext_res),
    .clamp_o(ext_clamp)
  );

  // flags: control write first, then sets from the completing op
  logic [N_ACC-1:0] ovf_d;
  logic             ext_sat_d, carry_d;

  always_comb begin
    ovf_d     = ctl_wr_i ? ctl_wdata_i[N_ACC-1:0] : ovf_o;
    ext_sat_d = ctl_wr_i ? ctl_wdata_i[N_ACC]     : ext_sat_o;
    carry_d   = ctl_wr_i ? ctl_wdata_i[N_ACC+1]   : carry_o;
    if (is_mac && |s1_sat)                ovf_d[s1_sel] = 1'b1;
    if (is_ext && ext_clamp)              ext_sat_d     = 1'b1;
    if (is_add && s1_op == OP_ADD_CO)     carry_d       = add_wide[DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o          <= '0;
      ext_sat_o      <= 1'b0;
      carry_o        <= 1'b0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      ovf_o          <= ovf_d;
      ext_sat_o      <= ext_sat_d;
      carry_o        <= carry_d;
      result_valid_o <= is_add || is_ext;
      if (is_ext)      result_o <= ext_res;
      else if (is_add) result_o <= add_wide[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/simd_mac_chk.sv
module simd_mac_chk import simd_mac_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_ACC  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [2:0]        op_code_i,
  input logic              ctl_wr_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o,
  input logic [N_ACC-1:0]  ovf_o,
  input logic              ext_sat_o,
  input logic              carry_o
);
  logic res_op, mac_op;
  assign res_op = op_valid_i && (op_code_i >= 3'(OP_ADD_CO));
  assign mac_op = op_valid_i && (op_code_i <= 3'(OP_CROSS));

  assert_sticky_ovf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  assert_ovf_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_o & ~$past(ovf_o)) != '0) |-> ($past(ctl_wr_i) || $past(mac_op, 2)));

  assert_valid_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(res_op, 2));

  assert_carry_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carry_o) |-> ($past(ctl_wr_i) ||
                           $past(op_valid_i && op_code_i == 3'(OP_ADD_CO), 2)));

  assert_ext_sat_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_sat_o) |-> ($past(ctl_wr_i) ||
                          $past(op_valid_i && op_code_i == 3'(OP_EXT_RS), 2)));

  assert_result_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> $stable(result_o));
endmodule

bind simd_mac_unit simd_mac_chk #(.DATA_W(DATA_W), .N_ACC(N_ACC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .op_valid_i    (op_valid_i),
  .op_code_i     (op_code_i),
  .ctl_wr_i      (ctl_wr_i),
  .result_o      (result_o),
  .result_valid_o(result_valid_o),
  .ovf_o         (ovf_o),
  .ext_sat_o     (ext_sat_o),
  .carry_o       (carry_o)
);

// File: tb/tb_simd_mac_unit.sv
module tb_simd_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  acc_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [4:0]  shift = '0;
  logic        ctl_wr = 1'b0;
  logic [5:0]  ctl_wd = '0;
  logic [31:0] result;
  logic        result_valid, ext_sat, carry;
  logic [3:0]  ovf;

  int vectors = 0, fails = 0;
  bit run_cmp = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  simd_mac_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .acc_sel_i(acc_sel), .src_a_i(src_a), .src_b_i(src_b), .shift_i(shift),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .result_o(result),
    .result_valid_o(result_valid), .ovf_o(ovf), .ext_sat_o(ext_sat), .carry_o(carry)
  );

  // ---------------- behavioural reference model ----------------
  logic signed [63:0] m_acc [4];
  logic [31:0] m_res;
  logic        m_rv, m_ext, m_car;
  logic [3:0]  m_ovf;
  string       m_tag;
  // op captured on the previous edge, completes on this edge
  logic        p_v;
  logic [2:0]  p_op;
  logic [1:0]  p_sel;
  logic [31:0] p_a, p_b;
  logic [4:0]  p_sh;

  function automatic longint q31(logic signed [15:0] a, logic signed [15:0] b);
    if (a == -16'sd32768 && b == -16'sd32768) return 64'sd2147483647;
    return 2 * (longint'(a) * longint'(b));
  endfunction

  longint ph, pl, comb;
  logic [32:0] wide;
  logic signed [64:0] e;
  logic [3:0]  n_ovf;
  logic        n_ext, n_car;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_acc[i] = '0;
      m_res = '0; m_rv = 0; m_ext = 0; m_car = 0; m_ovf = '0; m_tag = "R12";
      p_v = 0; p_op = '0; p_sel = '0; p_a = '0; p_b = '0; p_sh = '0;
    end else begin
      n_ovf = ctl_wr ? ctl_wd[3:0] : m_ovf;
      n_ext = ctl_wr ? ctl_wd[4]   : m_ext;
      n_car = ctl_wr ? ctl_wd[5]   : m_car;
      m_rv  = 0;
      if (p_v) begin
        if (p_op <= 3'd2) begin
          ph = q31(p_a[31:16], p_b[31:16]);
          pl = q31(p_a[15:0],  p_b[15:0]);
          if ((p_a[31:16] == 16'h8000 && p_b[31:16] == 16'h8000) ||
              (p_a[15:0]  == 16'h8000 && p_b[15:0]  == 16'h8000)) n_ovf[p_sel] = 1'b1;
          comb = (p_op == 3'd2) ? ph - pl : ph + pl;
          m_acc[p_sel] = (p_op == 3'd1) ? m_acc[p_sel] - comb : m_acc[p_sel] + comb;
        end else if (p_op <= 3'd4) begin
          wide  = {1'b0, p_a} + {1'b0, p_b} + ((p_op == 3'd4) ? 33'(m_car) : 33'd0);
          m_res = wide[31:0];
          m_rv  = 1;
          if (p_op == 3'd3) begin n_car = wide[32]; m_tag = "R5"; end
          else m_tag = "R6";
        end else begin
          e = {m_acc[p_sel][63], m_acc[p_sel]};
          if (p_op != 3'd5 && p_sh != 0) e = e + (65'sd1 <<< (p_sh - 1));
          e = e >>> p_sh;
          m_tag = (p_op == 3'd5) ? "R7" : (p_op == 3'd6) ? "R8" : "R9";
          if (p_op == 3'd7 && e > 65'sd2147483647) begin
            e = 65'sd2147483647; n_ext = 1'b1;
          end else if (p_op == 3'd7 && e < -65'sd2147483648) begin
            e = -65'sd2147483648; n_ext = 1'b1;
          end
          m_res = e[31:0];
          m_rv  = 1;
        end
      end
      m_ovf = n_ovf; m_ext = n_ext; m_car = n_car;
      p_v = op_valid; p_op = op_code; p_sel = acc_sel;
      p_a = src_a; p_b = src_b; p_sh = shift;
    end
  end

  // ---------------- per-cycle compare ----------------
  always @(negedge clk) begin
    if (rst_n && run_cmp && !done) begin
      vectors++;
      if (result_valid !== m_rv || result !== m_res) begin
        fails++;
        $display("FAIL %s R10 result act=%0d/%h exp=%0d/%h", m_rv ? m_tag : "R13",
                 result_valid, result, m_rv, m_res);
      end
      if (ovf !== m_ovf || ext_sat !== m_ext || carry !== m_car) begin
        fails++;
        $display("FAIL R11 flags act=%b/%b/%b exp=%b/%b/%b",
                 ovf, ext_sat, carry, m_ovf, m_ext, m_car);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic [1:0] sel,
                       input logic [31:0] a, input logic [31:0] b, input logic [4:0] sh,
                       input logic cw, input logic [5:0] cd);
    @(negedge clk);
    op_valid = v; op_code = op; acc_sel = sel; src_a = a; src_b = b;
    shift = sh; ctl_wr = cw; ctl_wd = cd;
  endtask

  task automatic idle2();
    issue(0, 0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [15:0] rnd_half();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12 result", result, 32'h0);
    chk("R12 flags", {25'd0, result_valid, ext_sat, carry, ovf}, 32'h0);
    run_cmp = 1'b1;

    // R1: -1 x -1 in both lanes, acc0
    issue(1, 3'd0, 2'd0, 32'h8000_8000, 32'h8000_8000, 0, 0, 0);
    issue(1, 3'd5, 2'd0, 0, 0, 5'd0, 0, 0);
    idle2();
    chk("R1 ext", result, 32'hFFFF_FFFE);
    chk("R1 ovf", {28'd0, ovf}, 32'h1);
    // R7 plain extract, R8 rounding
    issue(1, 3'd5, 2'd0, 0, 0, 5'd2, 0, 0); idle2();
    chk("R7", result, 32'h3FFF_FFFF);
    issue(1, 3'd6, 2'd0, 0, 0, 5'd2, 0, 0); idle2();
    chk("R8", result, 32'h4000_0000);
    // R9 saturating extract
    issue(1, 3'd7, 2'd0, 0, 0, 5'd0, 0, 0); idle2();
    chk("R9 res", result, 32'h7FFF_FFFF);
    chk("R9 flag", {31'd0, ext_sat}, 32'h1);
    // R5 carry out, R6 carry in
    issue(1, 3'd3, 2'd0, 32'hFFFF_FFFF, 32'h1, 0, 0, 0); idle2();
    chk("R5 sum", result, 32'h0);
    chk("R5 carry", {31'd0, carry}, 32'h1);
    issue(1, 3'd4, 2'd0, 32'h0, 32'h0, 0, 0, 0); idle2();
    chk("R6", result, 32'h1);
    // R2 R10: back-to-back dot adds on acc1 then extract
    issue(1, 3'd0, 2'd1, 32'h4000_0000, 32'h4000_0000, 0, 0, 0);
    issue(1, 3'd0, 2'd1, 32'h4000_0000, 32'h4000_0000, 0, 0, 0);
    issue(1, 3'd5, 2'd1, 0, 0, 5'd0, 0, 0);
    idle2();
    chk("R2 R10", result, 32'h4000_0000);
    // R3 dot subtract on acc2
    issue(1, 3'd1, 2'd2, 32'h4000_4000, 32'h4000_4000, 0, 0, 0);
    issue(1, 3'd5, 2'd2, 0, 0, 5'd0, 0, 0);
    idle2();
    chk("R3", result, 32'hC000_0000);
    // R4 cross on acc3
    issue(1, 3'd2, 2'd3, 32'h4000_2000, 32'h4000_2000, 0, 0, 0);
    issue(1, 3'd5, 2'd3, 0, 0, 5'd0, 0, 0);
    idle2();
    chk("R4", result, 32'h1800_0000);
    chk("R11 sticky", {28'd0, ovf}, 32'h1);
    // R11 clear by control write
    issue(0, 0, 0, 0, 0, 0, 1, 6'd0);
    issue(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 clear", {29'd0, ext_sat, carry, |ovf}, 32'h0);
    chk("R13 hold", result, 32'h1800_0000);

    // random dense stream
    for (int n = 0; n < 6000; n++) begin
      issue(($urandom % 10) != 0, 3'($urandom), 2'($urandom % ((n % 3 == 0) ? 1 : 4)),
            {rnd_half(), rnd_half()}, {rnd_half(), rnd_half()}, 5'($urandom),
            ($urandom % 25) == 0, 6'($urandom));
    end
    idle2();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule